// File: doc/BRIEF.md
# Interval-Reusable Scan Output Mask Unit

This unit sits between the outputs of a set of scan chains and a downstream X-canceling compactor. It holds one mask word with a bit per chain. That word stays in force across a whole interval of consecutive scan slices. The mask is computed off-line. Each slice arrives with a mask-control bit from the tester. When that bit is high, every chain whose mask bit is set has its output forced to 1, which hides an unknown value from the compactor. When the control bit is low, the slice passes untouched, so slices that hold must-observe values are never masked.

An interval counter runs down by one for each accepted slice. When it runs out, and also right after reset, the unit fetches a fresh mask over the narrow tester data input, a few bits per cycle. It holds `ready` low during the fetch so that shifting stalls. The interval length is sampled once, while reset is held, and stays fixed for the rest of the test.

Top module: `scan_mask_unit`

## Requirements
- R1: While `mask_ctl` is 1, every output bit whose active mask bit is 1 is driven to 1, whatever the input bit.
- R2: While `mask_ctl` is 0, `slice_out` equals `slice_in`. A chain whose active mask bit is 0 always passes its input bit unchanged.
- R3: `interval_len` is sampled only while `rst` is high. Changing it after reset leaves the interval length unchanged.
- R4: A slice counts as accepted only in a cycle where both `shift_en` and `ready` are high. Cycles with `shift_en` low do not count. After N accepted slices, where N is the sampled interval length, `ready` goes low and a mask reload begins.
- R5: After reset, and after every interval, the reload lasts exactly CHAINS/TCH cycles with `ready` low. In each of these cycles `tester_data` is taken. Beat k fills mask bits [k*TCH +: TCH], starting with beat 0 at the lowest bits. CHAINS must be a multiple of TCH.
- R6: While a reload is in progress, the previous mask stays in force. The mask is all zero after reset. The new mask governs `slice_out` from the first cycle in which `ready` is high again.
- R7: A sampled interval length of 0 behaves as an interval of one slice.
- R8: `shift_en` asserted while `ready` is low has no effect. It neither stretches nor shortens the load, and it does not count toward the next interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also samples `interval_len` |
| interval_len | input | CNT_W | Slices per mask interval (0 treated as 1) |
| tester_data | input | TCH | Mask beat from the tester channels |
| shift_en | input | 1 | Slice shift request |
| mask_ctl | input | 1 | Per-slice enable for masking |
| slice_in | input | CHAINS | Scan slice from the chain outputs |
| slice_out | output | CHAINS | Masked slice toward the compactor |
| ready | output | 1 | High when slices are accepted; low while the mask loads |

## Verification
The bench builds the unit with CHAINS=8, TCH=2 and CNT_W=4. A load therefore takes four beats, and the mask word is small enough that a beat-order mix-up changes it visibly. These settings allow the whole interval to be walked: eight slices with an idle gap, both control values, a reload that overlaps a stale shift request, and the zero-length interval after a second reset. The mask value 0x1E is chosen so that loading its beats in reverse order would produce a different word.

// File: rtl/scan_mask_pkg.sv
package scan_mask_pkg;

    typedef enum logic {
        ST_LOAD = 1'b0,
        ST_RUN  = 1'b1
    } mask_state_e;

    typedef struct packed {
        logic        load_en;
        logic        step;
    } seq_ctl_t;

    function automatic int unsigned beat_count(input int unsigned chains,
                                               input int unsigned tch);
        return chains / tch;
    endfunction

    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/mask_beat_loader.sv
module mask_beat_loader
    import scan_mask_pkg::*;
#(
    parameter int unsigned CHAINS = 16,
    parameter int unsigned TCH    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic [TCH-1:0]    tdata,
    output logic [CHAINS-1:0] assembled,
    output logic              last_beat
);
    localparam int unsigned BEATS = beat_count(CHAINS, TCH);
    localparam int unsigned BW    = idx_width(BEATS);

    logic [BW-1:0]     beat;
    logic [CHAINS-1:0] shadow;

    for (genvar k = 0; k < BEATS; k++) begin : g_slot
        assign assembled[k*TCH +: TCH] =
            (load_en && beat == BW'(k)) ? tdata : shadow[k*TCH +: TCH];
    end

    assign last_beat = load_en && (beat == BW'(BEATS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            beat   <= '0;
            shadow <= '0;
        end else if (load_en) begin
            shadow <= assembled;
            beat   <= last_beat ? '0 : beat + 1'b1;
        end
    end
endmodule

// File: rtl/interval_tracker.sv
module interval_tracker #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] interval_len,
    input  logic             reload,
    input  logic             step,
    output logic             expire
);
    logic [CNT_W-1:0] preset;
    logic [CNT_W-1:0] remain;

    assign expire = step && (remain == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            preset <= (interval_len == '0) ? CNT_W'(1) : interval_len;
            remain <= '0;
        end else if (reload) begin
            remain <= preset;
        end else if (step && remain != '0) begin
            remain <= remain - 1'b1;
        end
    end
endmodule

// File: rtl/mask_gate_array.sv
module mask_gate_array #(
    parameter int unsigned CHAINS = 16
) (
    input  logic [CHAINS-1:0] mask,
    input  logic              ctl,
    input  logic [CHAINS-1:0] din,
    output logic [CHAINS-1:0] dout
);
    for (genvar i = 0; i < CHAINS; i++) begin : g_chain
        logic hit;
        assign hit     = mask[i] & ctl;
        assign dout[i] = din[i] | hit;
    end
endmodule

// File: rtl/scan_mask_unit.sv
module scan_mask_unit
    import scan_mask_pkg::*;
#(
    parameter int unsigned CHAINS = 16,
    parameter int unsigned TCH    = 4,
    parameter int unsigned CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  interval_len,
    input  logic [TCH-1:0]    tester_data,
    input  logic              shift_en,
    input  logic              mask_ctl,
    input  logic [CHAINS-1:0] slice_in,
    output logic [CHAINS-1:0] slice_out,
    output logic              ready
);
    mask_state_e       state;
    seq_ctl_t          seq;
    logic [CHAINS-1:0] active_mask;
    logic [CHAINS-1:0] assembled;
    logic              last_beat;
    logic              expire;

    assign ready       = (state == ST_RUN);
    assign seq.load_en = (state == ST_LOAD);
    assign seq.step    = ready && shift_en;

    mask_beat_loader #(.CHAINS(CHAINS), .TCH(TCH)) u_loader (
        .clk       (clk),
        .rst       (rst),
        .load_en   (seq.load_en),
        .tdata     (tester_data),
        .assembled (assembled),
        .last_beat (last_beat)
    );

    interval_tracker #(.CNT_W(CNT_W)) u_interval (
        .clk          (clk),
        .rst          (rst),
        .interval_len (interval_len),
        .reload       (last_beat),
        .step         (seq.step),
        .expire       (expire)
    );

    mask_gate_array #(.CHAINS(CHAINS)) u_gates (
        .mask (active_mask),
        .ctl  (mask_ctl),
        .din  (slice_in),
        .dout (slice_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_LOAD;
            active_mask <= '0;
        end else begin
            case (state)
                ST_LOAD: if (last_beat) begin
                    active_mask <= assembled;
                    state       <= ST_RUN;
                end
                ST_RUN: if (expire) begin
                    state <= ST_LOAD;
                end
                default: state <= ST_LOAD;
            endcase
        end
    end
endmodule

// File: rtl/scan_mask_unit_chk.sv
module scan_mask_unit_chk #(
    parameter int unsigned CHAINS = 16,
    parameter int unsigned TCH    = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              shift_en,
    input logic              mask_ctl,
    input logic [CHAINS-1:0] slice_in,
    input logic [CHAINS-1:0] slice_out,
    input logic              ready,
    input logic [CHAINS-1:0] active_mask
);
    localparam int unsigned BEATS = CHAINS / TCH;

    logic [7:0] low_cnt;
    always_ff @(posedge clk) begin
        if (rst)         low_cnt <= '0;
        else if (!ready) low_cnt <= (low_cnt == 8'hFF) ? low_cnt : low_cnt + 1'b1;
        else             low_cnt <= '0;
    end

    AST_NEVER_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (slice_in & ~slice_out) == '0);                              // R1
    AST_PASS_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !mask_ctl |-> slice_out == slice_in);                        // R2
    AST_LOAD_LENGTH: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> low_cnt == 8'(BEATS));                      // R5
    AST_MASK_HELD: assert property (@(posedge clk) disable iff (rst)
        !$rose(ready) |-> $stable(active_mask));                     // R6
    AST_DROP_ON_SHIFT: assert property (@(posedge clk) disable iff (rst)
        $fell(ready) |-> $past(shift_en));                           // R4
endmodule

bind scan_mask_unit scan_mask_unit_chk #(.CHAINS(CHAINS), .TCH(TCH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .shift_en    (shift_en),
    .mask_ctl    (mask_ctl),
    .slice_in    (slice_in),
    .slice_out   (slice_out),
    .ready       (ready),
    .active_mask (active_mask)
);

// File: tb/scan_mask_unit_tb.sv
module scan_mask_unit_tb;
    localparam int unsigned CHAINS = 8;
    localparam int unsigned TCH    = 2;
    localparam int unsigned CNT_W  = 4;
    localparam int unsigned BEATS  = CHAINS / TCH;

    // {slice_in, mask_ctl, expected} with active mask 8'hA5
    localparam logic [16:0] VEC [8] = '{
        {8'h00, 1'b1, 8'hA5},
        {8'h00, 1'b0, 8'h00},
        {8'hFF, 1'b1, 8'hFF},
        {8'h5A, 1'b1, 8'hFF},
        {8'h5A, 1'b0, 8'h5A},
        {8'h0F, 1'b1, 8'hAF},
        {8'h30, 1'b1, 8'hB5},
        {8'h81, 1'b0, 8'h81}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [CNT_W-1:0]  interval_len = 4'd8;
    logic [TCH-1:0]    tester_data = '0;
    logic              shift_en = 1'b0;
    logic              mask_ctl = 1'b0;
    logic [CHAINS-1:0] slice_in = '0;
    logic [CHAINS-1:0] slice_out;
    logic              ready;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    scan_mask_unit #(.CHAINS(CHAINS), .TCH(TCH), .CNT_W(CNT_W)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .interval_len (interval_len),
        .tester_data  (tester_data),
        .shift_en     (shift_en),
        .mask_ctl     (mask_ctl),
        .slice_in     (slice_in),
        .slice_out    (slice_out),
        .ready        (ready)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset(input logic [CNT_W-1:0] len);
        rst = 1'b1;
        interval_len = len;
        tick();
        tick();
        rst = 1'b0;
    endtask

    // drives beats lowest first; checks the old mask still governs (R6)
    task automatic load_mask(input logic [CHAINS-1:0] newm, input logic [CHAINS-1:0] oldm);
        slice_in = '0;
        mask_ctl = 1'b1;
        for (int k = 0; k < int'(BEATS); k++) begin
            tester_data = newm[k*TCH +: TCH];
            #2;
            check("R5 ready low during load", 32'(ready), 32'd0);
            check("R6 old mask during load", 32'(slice_out), 32'(oldm));
            tick();
        end
        #2;
        check("R5 ready after load", 32'(ready), 32'd1);
        check("R6 new mask in force", 32'(slice_out), 32'(newm));
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset(4'd8);
        mask_ctl = 1'b1;
        slice_in = 8'h00;
        #2;
        check("R5 reset ready low", 32'(ready), 32'd0);
        check("R6 reset mask zero", 32'(slice_out), 32'h00);
        interval_len = 4'd3;      // R3: must be ignored
        shift_en     = 1'b1;      // R8: ignored during load
        load_mask(8'hA5, 8'h00);
        shift_en     = 1'b0;

        // table walk: eight slices, idle gap after entry 3 (R4)
        for (int i = 0; i < 8; i++) begin
            slice_in = VEC[i][16:9];
            mask_ctl = VEC[i][8];
            shift_en = 1'b1;
            #2;
            check(VEC[i][8] ? "R1 masked slice" : "R2 pass slice",
                  32'(slice_out), 32'(VEC[i][7:0]));
            check("R4 R3 R8 ready within interval", 32'(ready), 32'd1);
            tick();
            if (i == 3) begin
                shift_en = 1'b0;
                tick();
                tick();
                #2;
                check("R4 idle does not count", 32'(ready), 32'd1);
            end
        end
        shift_en = 1'b0;
        #2;
        check("R4 ready drops after N slices", 32'(ready), 32'd0);

        load_mask(8'h1E, 8'hA5);
        slice_in = 8'h41;
        mask_ctl = 1'b1;
        #2;
        check("R2 zero mask bit passes", 32'(slice_out), 32'h5F);
        mask_ctl = 1'b0;
        #2;
        check("R2 ctl low passes", 32'(slice_out), 32'h41);

        // R7: zero interval acts as one slice
        @(negedge clk);
        do_reset(4'd0);
        load_mask(8'hFF, 8'h00);
        shift_en = 1'b1;
        tick();
        shift_en = 1'b0;
        #2;
        check("R7 zero interval is one slice", 32'(ready), 32'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule